// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Cell

This block is one configurable logic cell with a single output. A small programmable AND plane builds product terms. Each term is the AND of any chosen subset of the literal inputs, and each chosen literal is taken either true or inverted. An OR stage then sums the enabled product terms together with the enabled extra inputs, which skip the AND plane entirely. One configuration bit decides whether the cell output is the raw sum in the same cycle or the sum held in a D flip-flop that is updated on every rising clock edge.

The configuration is a single vector of `CFG_W` bits. It is written serially, MSB first, into a shadow register while the shift strobe is high. The shadow has no effect on the logic until a commit pulse copies it into the active configuration in one step, so a new function can be staged while the cell keeps working with the old one. With the default parameters there are 4 literals, 4 product terms and 2 extra inputs, which gives a 39-bit configuration.

Top module: `pla_cell`

## Requirements
- R1: Product term p is the AND of every literal i whose true-select bit (active bit 2*(N_LIT*p+i)) is set, taken as is, and of every literal whose invert-select bit (active bit 2*(N_LIT*p+i)+1) is set, taken inverted.
- R2: A product term with no select bit set evaluates to 0. A term that selects both polarities of one literal also evaluates to 0.
- R3: The sum is the OR of the product terms whose enable bit (active bit 2*N_LIT*N_PT+p) is set and the extra inputs whose enable bit (active bit 2*N_LIT*N_PT+N_PT+e) is set. The extra inputs pass to the OR stage without going through the AND plane.
- R4: When the mode bit (active bit CFG_W-1) is 0, `f_out` equals the current sum in the same cycle, with no clock edge needed.
- R5: When the mode bit is 1, `f_out` equals the sum sampled at the previous rising edge, and a change on the inputs does not alter `f_out` before the next edge.
- R6: On each rising edge with `cfg_shift` high, the shadow shifts left by one and `cfg_sdi` enters bit 0. After CFG_W shifts, the first bit sent sits in bit CFG_W-1.
- R7: The shadow contents do not affect `f_out` until a rising edge with `cfg_commit` high, which copies the shadow into the active configuration.
- R8: When `cfg_commit` and `cfg_shift` are both high in the same cycle, the active configuration takes the shadow value from before that cycle's shift, and the shift still takes place.
- R9: A rising edge with `rst_n` low clears the flip-flop, the shadow and the active configuration, so `f_out` is 0 afterwards.
- R10: With literals 0, 1, 2 used as a, b, c and the two extra inputs as g, h, the cell can be configured to compute f = ab + bc' + g + h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lit_in | input | N_LIT | Literal inputs to the AND plane |
| ext_in | input | N_EXT | Extra inputs fed straight into the OR stage |
| cfg_shift | input | 1 | Shift strobe for the configuration shadow |
| cfg_sdi | input | 1 | Serial configuration data, MSB first |
| cfg_commit | input | 1 | Copies the shadow into the active configuration |
| f_out | output | 1 | Cell output, either combinational or registered |

## Verification
Two pairs of operations can land on the same clock edge. The first pair is a commit and a shift. The bench stages a function in the shadow, then raises both strobes together with a 1 on the serial input. It checks that the cell then computes the staged function and not the shifted one. A second commit then shows the shifted value, which confirms the shift took place too. The second pair is a registered-output capture and an input change. Registered sweeps judge it by checking, just after each new input is driven, that the output still holds the previous sum, and one cycle later that it has the new one.

// File: rtl/pla_cell_pkg.sv
// Package: shared sizing helpers for the programmable logic cell.
// Assumes the configuration layout used by pla_cell: literal select
// pairs first, then term enables, extra-input enables and the mode bit on top.
package pla_cell_pkg;

    // Total configuration width for a given cell size.
    function automatic int cfg_width(input int n_lit, input int n_pt, input int n_ext);
        return n_pt * 2 * n_lit + n_pt + n_ext + 1;
    endfunction

    // Width of the AND-plane select field.
    function automatic int mask_width(input int n_lit, input int n_pt);
        return n_pt * 2 * n_lit;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
// Module: serial configuration store with a shadow and an active copy.
// The shadow shifts in serially (new bit at LSB, so data arrives MSB first).
// A commit copies the pre-shift shadow into the active copy.
// Assumes synchronous active-low reset clears both copies.
module pla_cfg_chain #(
    parameter int W = 39
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         commit,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] active_q
);

    // Shadow register: serial shift path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (shift_en) begin
            shadow_q <= {shadow_q[W-2:0], sdi};
        end
    end

    // Active register: takes the shadow as it stood before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (commit) begin
            active_q <= shadow_q;
        end
    end

endmodule

// File: rtl/pla_and_array.sv
// Module: programmable AND plane.
// Each term has 2*N_LIT select bits: even bit = literal true, odd bit =
// literal inverted. A term with no select bit set yields 0.
module pla_and_array #(
    parameter int N_LIT = 4,
    parameter int N_PT  = 4
) (
    input  logic [N_LIT-1:0]        lit,
    input  logic [N_PT*2*N_LIT-1:0] sel,
    output logic [N_PT-1:0]         term
);

    localparam int TW = 2 * N_LIT;

    logic [TW-1:0] dual_lit;

    // Expand each literal into its true and inverted forms.
    always_comb begin
        for (int i = 0; i < N_LIT; i++) begin
            dual_lit[2*i]   = lit[i];
            dual_lit[2*i+1] = ~lit[i];
        end
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [TW-1:0] m;
        assign m = sel[p*TW +: TW];
        // Term is the AND of selected polarised literals, forced to 0 if empty.
        assign term[p] = (|m) & (&(dual_lit | ~m));
    end

endmodule

// File: rtl/pla_or_stage.sv
// Module: programmable OR stage.
// Sums enabled product terms and enabled extra inputs; the extra inputs
// come straight from the cell pins, not through the AND plane.
module pla_or_stage #(
    parameter int N_PT  = 4,
    parameter int N_EXT = 2
) (
    input  logic [N_PT-1:0]  term,
    input  logic [N_PT-1:0]  term_en,
    input  logic [N_EXT-1:0] ext,
    input  logic [N_EXT-1:0] ext_en,
    output logic             sum
);

    // Single wide OR over both masked groups.
    always_comb begin
        sum = (|(term & term_en)) | (|(ext & ext_en));
    end

endmodule

// File: rtl/pla_cell.sv
// Module: top of the programmable sum-of-products logic cell.
// Combines the configuration store, AND plane, OR stage and an output
// flip-flop with a 2:1 select. The flip-flop captures the sum on every edge;
// the mode bit (top configuration bit) picks flop or raw sum.
// Assumes synchronous active-low reset.
module pla_cell
    import pla_cell_pkg::*;
#(
    parameter int N_LIT = 4,
    parameter int N_PT  = 4,
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LIT-1:0] lit_in,
    input  logic [N_EXT-1:0] ext_in,
    input  logic             cfg_shift,
    input  logic             cfg_sdi,
    input  logic             cfg_commit,
    output logic             f_out
);

    localparam int MASK_W  = mask_width(N_LIT, N_PT);
    localparam int CFG_W   = cfg_width(N_LIT, N_PT, N_EXT);
    localparam int PTEN_LO = MASK_W;
    localparam int EXT_LO  = MASK_W + N_PT;
    localparam int MODE_B  = CFG_W - 1;

    logic [CFG_W-1:0] shadow_cfg;
    logic [CFG_W-1:0] active_cfg;
    logic [N_PT-1:0]  pt;
    logic             or_sum;
    logic             flop_q;

    pla_cfg_chain #(.W(CFG_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .sdi      (cfg_sdi),
        .commit   (cfg_commit),
        .shadow_q (shadow_cfg),
        .active_q (active_cfg)
    );

    pla_and_array #(.N_LIT(N_LIT), .N_PT(N_PT)) and_i (
        .lit  (lit_in),
        .sel  (active_cfg[MASK_W-1:0]),
        .term (pt)
    );

    pla_or_stage #(.N_PT(N_PT), .N_EXT(N_EXT)) or_i (
        .term    (pt),
        .term_en (active_cfg[PTEN_LO +: N_PT]),
        .ext     (ext_in),
        .ext_en  (active_cfg[EXT_LO +: N_EXT]),
        .sum     (or_sum)
    );

    // Output flip-flop: holds the sum from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flop_q <= 1'b0;
        end else begin
            flop_q <= or_sum;
        end
    end

    // Output select: registered or combinational.
    always_comb begin
        f_out = active_cfg[MODE_B] ? flop_q : or_sum;
    end

endmodule

// File: rtl/pla_cell_chk.sv
// Checker: temporal properties of the logic cell, bound into pla_cell.
// Assumes the configuration layout described in pla_cell.
module pla_cell_chk #(
    parameter int N_LIT = 4,
    parameter int N_PT  = 4,
    parameter int N_EXT = 2
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         cfg_shift,
    input logic                                         cfg_sdi,
    input logic                                         cfg_commit,
    input logic [pla_cell_pkg::cfg_width(N_LIT, N_PT, N_EXT)-1:0] shadow,
    input logic [pla_cell_pkg::cfg_width(N_LIT, N_PT, N_EXT)-1:0] active,
    input logic [N_PT-1:0]                              pt,
    input logic                                         sum,
    input logic                                         flop_q,
    input logic                                         f_out
);

    localparam int CFG_W  = pla_cell_pkg::cfg_width(N_LIT, N_PT, N_EXT);
    localparam int MASK_W = pla_cell_pkg::mask_width(N_LIT, N_PT);

    // R2: terms with empty select fields stay low.
    a_r2_empty_terms_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active[MASK_W-1:0] == '0) |-> (pt == '0));

    // R4: combinational mode passes the sum straight through.
    a_r4_comb_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !active[CFG_W-1] |-> (f_out == sum));

    // R5: flip-flop holds last edge's sum.
    a_r5_flop_follows_sum: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flop_q == $past(sum)));

    // R6: shift moves the shadow left, serial bit at LSB.
    a_r6_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (shadow == {$past(shadow[CFG_W-2:0]), $past(cfg_sdi)}));

    // R7: active configuration is stable without a commit.
    a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_commit |=> $stable(active));

    // R8: commit copies the pre-shift shadow.
    a_r8_commit_preshift: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_commit |=> (active == $past(shadow)));

    // R9: after a reset edge all state is clear.
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (flop_q == 1'b0 && active == '0 && shadow == '0));

endmodule

bind pla_cell pla_cell_chk #(.N_LIT(N_LIT), .N_PT(N_PT), .N_EXT(N_EXT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_shift  (cfg_shift),
    .cfg_sdi    (cfg_sdi),
    .cfg_commit (cfg_commit),
    .shadow     (shadow_cfg),
    .active     (active_cfg),
    .pt         (pt),
    .sum        (or_sum),
    .flop_q     (flop_q),
    .f_out      (f_out)
);

// File: tb/pla_cell_tb_top.sv
// Bench: sweeps all literal/extra input patterns under a set of configurations
// and compares against an arithmetic model of the requirements.
module pla_cell_tb_top;

    localparam int NL = 4;
    localparam int NP = 4;
    localparam int NE = 2;
    localparam int W  = NP * 2 * NL + NP + NE + 1;
    localparam int MW = NP * 2 * NL;
    localparam int NV = 1 << (NL + NE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lit_in = '0;
    logic [NE-1:0] ext_in = '0;
    logic          cfg_shift = 1'b0;
    logic          cfg_sdi = 1'b0;
    logic          cfg_commit = 1'b0;
    logic          f_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;

    pla_cell #(.N_LIT(NL), .N_PT(NP), .N_EXT(NE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lit_in     (lit_in),
        .ext_in     (ext_in),
        .cfg_shift  (cfg_shift),
        .cfg_sdi    (cfg_sdi),
        .cfg_commit (cfg_commit),
        .f_out      (f_out)
    );

    // Model of R1..R3: sum of products from a configuration word.
    function automatic logic model(input logic [W-1:0] c, input logic [NL-1:0] l,
                                   input logic [NE-1:0] x);
        logic s = 1'b0;
        for (int p = 0; p < NP; p++) begin
            logic t = 1'b1;
            logic any = 1'b0;
            for (int i = 0; i < NL; i++) begin
                if (c[2*(NL*p+i)])   begin any = 1'b1; t = t & l[i];  end
                if (c[2*(NL*p+i)+1]) begin any = 1'b1; t = t & ~l[i]; end
            end
            s = s | (c[MW+p] & any & t);
        end
        for (int e = 0; e < NE; e++) s = s | (c[MW+NP+e] & x[e]);
        return s;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: f_out=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic shift_in(input logic [W-1:0] c);
        for (int k = W - 1; k >= 0; k--) begin
            cfg_shift = 1'b1;
            cfg_sdi   = c[k];
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        cfg_sdi   = 1'b0;
    endtask

    task automatic commit_cfg();
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    // Combinational sweep over every input pattern.
    task automatic sweep_comb(input logic [W-1:0] c, input string req);
        for (int v = 0; v < NV; v++) begin
            lit_in = v[NL-1:0];
            ext_in = v[NL +: NE];
            #1;
            check(f_out, model(c, lit_in, ext_in), req);
            @(negedge clk);
        end
    endtask

    // Registered sweep: output holds old sum until the next edge.
    task automatic sweep_reg(input logic [W-1:0] c, input string req);
        logic prev = 1'b0;
        for (int v = 0; v < NV; v++) begin
            lit_in = v[NL-1:0];
            ext_in = v[NL +: NE];
            #1;
            if (v > 0) check(f_out, prev, req);
            @(negedge clk);
            prev = model(c, v[NL-1:0], v[NL +: NE]);
            check(f_out, prev, req);
        end
    endtask

    function automatic logic [W-1:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng[W-1:0];
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [W-1:0] cfg_f;
        logic [W-1:0] cfg_a;
        logic [W-1:0] cfg_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state, output low for all inputs.
        sweep_comb('0, "R9 reset state");

        // R10/R1/R3: f = ab + bc' + g + h with a,b,c = literal 0,1,2.
        cfg_f = '0;
        cfg_f[0] = 1'b1;               // term0: a true
        cfg_f[2] = 1'b1;               // term0: b true
        cfg_f[2*(NL+1)] = 1'b1;        // term1: b true
        cfg_f[2*(NL+2)+1] = 1'b1;      // term1: c inverted
        cfg_f[MW] = 1'b1;
        cfg_f[MW+1] = 1'b1;
        cfg_f[MW+NP] = 1'b1;
        cfg_f[MW+NP+1] = 1'b1;
        // R7: staged shadow does not act before commit.
        shift_in(cfg_f);
        lit_in = 4'b0011; ext_in = '0; #1;
        check(f_out, 1'b0, "R7 no effect before commit");
        @(negedge clk);
        commit_cfg();
        sweep_comb(cfg_f, "R10 ab+bc'+g+h");

        // R2: all terms enabled, empty selects, no extras -> always 0.
        cfg_a = '0;
        cfg_a[MW +: NP] = '1;
        shift_in(cfg_a); commit_cfg();
        sweep_comb(cfg_a, "R2 empty terms");

        // R2: term selects both polarities of literal 3.
        cfg_a = '0;
        cfg_a[2*3] = 1'b1; cfg_a[2*3+1] = 1'b1; cfg_a[0] = 1'b1;
        cfg_a[MW] = 1'b1;
        shift_in(cfg_a); commit_cfg();
        sweep_comb(cfg_a, "R2 contradictory term");

        // R1/R3: pseudo-random combinational configurations.
        for (int r = 0; r < 6; r++) begin
            cfg_a = next_rand() & next_rand();
            cfg_a[MW +: NP] = next_rand()[NP-1:0];
            cfg_a[W-1] = 1'b0;
            shift_in(cfg_a); commit_cfg();
            sweep_comb(cfg_a, "R1 R3 random comb");
        end

        // R4/R5: registered mode with the example function and a random one.
        cfg_b = cfg_f; cfg_b[W-1] = 1'b1;
        shift_in(cfg_b); commit_cfg();
        sweep_reg(cfg_b, "R5 registered ab+bc'+g+h");
        cfg_b = next_rand() & next_rand(); cfg_b[MW +: NP] = '1; cfg_b[W-1] = 1'b1;
        shift_in(cfg_b); commit_cfg();
        sweep_reg(cfg_b, "R5 registered random");

        // R6/R8: commit and shift in the same cycle.
        cfg_a = '0; cfg_a[MW+NP] = 1'b1;   // f = extra input 0 only
        shift_in(cfg_a);
        cfg_commit = 1'b1; cfg_shift = 1'b1; cfg_sdi = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0; cfg_shift = 1'b0; cfg_sdi = 1'b0;
        lit_in = '0; ext_in = 2'b01; #1;
        check(f_out, 1'b1, "R8 commit takes pre-shift value (g)");
        ext_in = 2'b10; #1;
        check(f_out, 1'b0, "R8 commit takes pre-shift value (h)");
        @(negedge clk);
        commit_cfg();
        sweep_comb({cfg_a[W-2:0], 1'b1}, "R6 shift also happened");

        // R9: reset clears flop and configuration.
        cfg_b = '0; cfg_b[MW+NP] = 1'b1; cfg_b[W-1] = 1'b1;
        shift_in(cfg_b); commit_cfg();
        ext_in = 2'b01; lit_in = '0;
        @(negedge clk);
        check(f_out, 1'b1, "R9 pre-reset registered g");
        rst_n = 1'b0;
        @(negedge clk);
        check(f_out, 1'b0, "R9 output after reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(f_out, 1'b0, "R9 config cleared");
        commit_cfg();
        sweep_comb('0, "R9 shadow cleared");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule